// File: doc/BRIEF.md
# Windowed Indirect Register Bridge

This block lets a host with a very small address window reach a 64 KiB internal byte space. The host sees four byte locations. The first is a mode byte that the host can always reach. The next two hold a 16-bit pointer into the internal space. The last is a data port. Each read or write of the data port becomes a one-cycle strobe on an internal byte bus at the pointer's address. When the host enables post-increment, the pointer advances after every data access, so a burst needs only one pointer load.

The bridge also handles the soft reset. Setting the top mode bit starts a reset window of fixed length. During that window a reset line to the internal register file and buffer stays high, the mode bits and the pointer are cleared, and the host cannot write. The bridge holds a 16-bit identity register in the internal space, stored big-endian. It reloads its fixed signature value on every reset, so the host can read it back to check that the part is present.

Host accesses take one cycle each. `host_sel` qualifies an access, `host_wr` gives its direction and `host_off` selects one of the four window bytes. Read data appears on `host_rdata` from the clock edge that follows the read strobe, and it holds until the next read.

Top module: `ibr_bridge`

## Requirements
- R1: The window is decoded by `host_off`: 0 is the mode byte, 1 is the pointer high byte, 2 is the pointer low byte and 3 is the data port. Reads of offsets 1 and 2 return the current pointer, with the high byte at offset 1. Read data is registered: it appears after the edge that samples the read and holds until the next read.
- R2: The mode byte has these fields. Bit 0 enables the pointer and data ports. Bit 1 enables post-increment. Bit 4 is stored and driven on `ping_block`. Bit 7 is the reset bit. The other bits are not stored and read as 0.
- R3: While mode bit 0 is clear, writes to offsets 1 to 3 are ignored, reads of offsets 1 to 3 return 0, and no internal strobe is issued.
- R4: A data-port read pulses `ib_rd` in the same cycle, with `ib_addr` equal to the pointer. The byte returned on `ib_rdata` is the next value of `host_rdata`.
- R5: A data-port write pulses `ib_wr` in the same cycle, with `ib_addr` equal to the pointer and `ib_wdata` equal to the host byte. `ib_rd` and `ib_wr` are never high together.
- R6: With mode bit 1 set, each data-port access adds one to the pointer, and 0xFFFF wraps to 0x0000. With bit 1 clear, the pointer does not change.
- R7: A mode-byte write that does not set bit 7 leaves the pointer unchanged.
- R8: A mode write with bit 7 set starts a soft reset. The reset lasts exactly RST_CYCLES cycles. During it, `ib_srst` is high and the mode byte reads 0x80. The reset clears the pointer and the mode bits, and host writes are ignored while it runs. Bit 7 then clears by itself.
- R9: The identity register occupies internal address ID_ADDR (high byte) and ID_ADDR+1 (low byte). It reads 0x07D0 after any reset. It can be written through the data port. Accesses to it produce no internal strobe.
- R10: No internal strobe is issued while `ib_srst` is high.
- R11: After `rst_n` is asserted, the mode byte reads 0, `ping_block` is 0, `host_rdata` is 0 and `ib_srst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | Access direction: 1 write, 0 read |
| host_off | input | 2 | Window byte select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |
| ib_addr | output | 16 | Internal byte address (the pointer) |
| ib_rd | output | 1 | Internal read strobe |
| ib_wr | output | 1 | Internal write strobe |
| ib_wdata | output | 8 | Internal write byte |
| ib_rdata | input | 8 | Internal read byte, valid in the cycle `ib_rd` is high |
| ib_srst | output | 1 | Soft reset to the internal register file and buffer |
| ping_block | output | 1 | Stored ping-block mode bit |

## Verification
The properties assume a single host that presents at most one access per cycle. They also assume that `host_off` and `host_wdata` are stable for the whole cycle in which `host_sel` is high. Finally, they assume that `ib_rdata` settles within the same cycle as `ib_rd`. The stimulus meets these assumptions in three ways. It changes every host input only at the falling clock edge. It never leaves `host_sel` high longer than the one cycle of an access. It computes `ib_rdata` as a pure function of `ib_addr`, so every internal read returns a known byte at once.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int IB_AW = 16;
  localparam int IB_DW = 8;

  localparam logic [1:0] OFF_MODE = 2'd0;
  localparam logic [1:0] OFF_AHI  = 2'd1;
  localparam logic [1:0] OFF_ALO  = 2'd2;
  localparam logic [1:0] OFF_DATA = 2'd3;

  localparam int MB_IND = 0;
  localparam int MB_AI  = 1;
  localparam int MB_PB  = 4;
  localparam int MB_RST = 7;

  typedef struct packed {
    logic pb;
    logic ai;
    logic ind;
  } mode_t;
endpackage

// File: rtl/ibr_reset_seq.sv
module ibr_reset_seq #(
  parameter int RST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = CW'(RST_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ibr_addr_ptr.sv
module ibr_addr_ptr #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic          step,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)
      ptr_d = '0;
    else if (ld_hi)
      ptr_d = {wdata, ptr_q[AW-DW-1:0]};
    else if (ld_lo)
      ptr_d = {ptr_q[AW-1:DW], wdata};
    else if (step)
      ptr_d = ptr_q + {{(AW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/ibr_ident_reg.sv
module ibr_ident_reg #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] ID_ADDR  = 16'h0017,
  parameter logic [15:0] ID_RESET = 16'h07D0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic            hit,
  output logic [DW-1:0]   rdata,
  output logic [2*DW-1:0] value
);
  localparam logic [AW-1:0] ADDR_HI = AW'(ID_ADDR);
  localparam logic [AW-1:0] ADDR_LO = AW'(ID_ADDR) + {{(AW-1){1'b0}}, 1'b1};

  logic [2*DW-1:0] val_q, val_d;
  logic            hit_hi, hit_lo;

  assign hit_hi = (addr == ADDR_HI);
  assign hit_lo = (addr == ADDR_LO);
  assign hit    = hit_hi | hit_lo;

  always_comb begin
    val_d = val_q;
    if (clr)
      val_d = ID_RESET;
    else if (wr_en && hit_hi)
      val_d = {wdata, val_q[DW-1:0]};
    else if (wr_en && hit_lo)
      val_d = {val_q[2*DW-1:DW], wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= ID_RESET;
    else        val_q <= val_d;
  end

  assign rdata = hit_hi ? val_q[2*DW-1:DW] : val_q[DW-1:0];
  assign value = val_q;
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int          RST_CYCLES = 64,
  parameter logic [15:0] ID_ADDR    = 16'h0017,
  parameter logic [15:0] ID_RESET   = 16'h07D0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel,
  input  logic             host_wr,
  input  logic [1:0]       host_off,
  input  logic [IB_DW-1:0] host_wdata,
  output logic [IB_DW-1:0] host_rdata,
  output logic [IB_AW-1:0] ib_addr,
  output logic             ib_rd,
  output logic             ib_wr,
  output logic [IB_DW-1:0] ib_wdata,
  input  logic [IB_DW-1:0] ib_rdata,
  output logic             ib_srst,
  output logic             ping_block
);
  // reset: asserted at once, released through two flops
  logic [1:0] sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  // access decode
  logic busy, start, soft_clr, port_en;
  logic mode_wr, data_acc, id_hit;
  logic ld_hi, ld_lo, step;

  assign mode_wr  = host_sel && host_wr && (host_off == OFF_MODE) && !busy;
  assign start    = mode_wr && host_wdata[MB_RST];
  assign soft_clr = start || busy;

  mode_t mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (soft_clr) begin
      mode_d = '0;
    end else if (mode_wr) begin
      mode_d.pb  = host_wdata[MB_PB];
      mode_d.ai  = host_wdata[MB_AI];
      mode_d.ind = host_wdata[MB_IND];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) mode_q <= '0;
    else          mode_q <= mode_d;
  end

  assign port_en  = mode_q.ind && !busy;
  assign data_acc = host_sel && (host_off == OFF_DATA) && port_en;
  assign ld_hi    = host_sel && host_wr && (host_off == OFF_AHI) && port_en;
  assign ld_lo    = host_sel && host_wr && (host_off == OFF_ALO) && port_en;
  assign step     = data_acc && mode_q.ai;

  ibr_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rseq (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (start),
    .busy  (busy)
  );

  logic [IB_AW-1:0] ptr_q;

  ibr_addr_ptr #(.AW(IB_AW), .DW(IB_DW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (soft_clr),
    .ld_hi (ld_hi),
    .ld_lo (ld_lo),
    .step  (step),
    .wdata (host_wdata),
    .ptr   (ptr_q)
  );

  logic [IB_DW-1:0]   id_rdata;
  logic [2*IB_DW-1:0] id_val;

  ibr_ident_reg #(
    .AW(IB_AW), .DW(IB_DW), .ID_ADDR(ID_ADDR), .ID_RESET(ID_RESET)
  ) u_id (
    .clk   (clk),
    .rst_n (rst_i_n),
    .clr   (soft_clr),
    .addr  (ptr_q),
    .wr_en (data_acc && host_wr),
    .wdata (host_wdata),
    .hit   (id_hit),
    .rdata (id_rdata),
    .value (id_val)
  );

  // internal bus
  assign ib_addr  = ptr_q;
  assign ib_wdata = host_wdata;
  assign ib_rd    = data_acc && !host_wr && !id_hit;
  assign ib_wr    = data_acc &&  host_wr && !id_hit;
  assign ib_srst  = busy;
  assign ping_block = mode_q.pb;

  // host read path
  logic [IB_DW-1:0] rd_mode, rd_mux, hr_q, hr_d;

  always_comb begin
    rd_mode         = '0;
    rd_mode[MB_RST] = busy;
    rd_mode[MB_PB]  = mode_q.pb;
    rd_mode[MB_AI]  = mode_q.ai;
    rd_mode[MB_IND] = mode_q.ind;
  end

  always_comb begin
    rd_mux = '0;
    case (host_off)
      OFF_MODE: rd_mux = rd_mode;
      OFF_AHI:  rd_mux = port_en ? ptr_q[IB_AW-1:IB_DW] : '0;
      OFF_ALO:  rd_mux = port_en ? ptr_q[IB_DW-1:0] : '0;
      default:  rd_mux = port_en ? (id_hit ? id_rdata : ib_rdata) : '0;
    endcase
  end

  always_comb begin
    hr_d = hr_q;
    if (host_sel && !host_wr) hr_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) hr_q <= '0;
    else          hr_q <= hr_d;
  end

  assign host_rdata = hr_q;
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk #(
  parameter int          RST_CYCLES = 64,
  parameter logic [15:0] ID_RESET   = 16'h07D0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel,
  input logic        host_wr,
  input logic [1:0]  host_off,
  input logic [7:0]  host_wdata,
  input logic        ib_rd,
  input logic        ib_wr,
  input logic        ib_srst,
  input logic [15:0] ptr,
  input logic        ai,
  input logic        ind,
  input logic [15:0] id_val
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (ib_srst) hi_cnt <= hi_cnt + 32'd1;
    else              hi_cnt <= '0;
  end

  p_srst_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ib_srst |-> (!ib_rd && !ib_wr));

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ib_rd && ib_wr));

  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_off == 2'd3 && ind && ai && !ib_srst)
      |=> (ptr == $past(ptr) + 16'd1));

  p_mode_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && host_wr && host_off == 2'd0 && !ib_srst && !host_wdata[7])
      |=> $stable(ptr));

  p_reset_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ib_srst) |-> (hi_cnt == 32'(RST_CYCLES)));

  p_id_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ib_srst) |-> (id_val == ID_RESET));
endmodule

bind ibr_bridge ibr_bridge_chk #(
  .RST_CYCLES (RST_CYCLES),
  .ID_RESET   (ID_RESET)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_off   (host_off),
  .host_wdata (host_wdata),
  .ib_rd      (ib_rd),
  .ib_wr      (ib_wr),
  .ib_srst    (ib_srst),
  .ptr        (ptr_q),
  .ai         (mode_q.ai),
  .ind        (mode_q.ind),
  .id_val     (id_val)
);

// File: tb/ibr_bridge_tb.sv
module ibr_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NRST       = 6;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        host_sel;
  logic        host_wr;
  logic [1:0]  host_off;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic [15:0] ib_addr;
  logic        ib_rd;
  logic        ib_wr;
  logic [7:0]  ib_wdata;
  logic [7:0]  ib_rdata;
  logic        ib_srst;
  logic        ping_block;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural model state
  int m_cnt, m_pb, m_ai, m_ind, m_addr, m_id, m_hr;

  ibr_bridge #(.RST_CYCLES(NRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ib_addr(ib_addr), .ib_rd(ib_rd), .ib_wr(ib_wr), .ib_wdata(ib_wdata),
    .ib_rdata(ib_rdata), .ib_srst(ib_srst), .ping_block(ping_block)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // internal memory: a pure function of the address
  function automatic int mem_byte(input int a);
    return ((a >> 8) ^ a ^ 8'h5A) & 8'hFF;
  endfunction
  assign ib_rdata = 8'(mem_byte(int'(ib_addr)));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_id(input int a);
    return (a == 16'h0017) || (a == 16'h0018);
  endfunction

  task automatic compare(input bit s, input bit w, input int off, input int d);
    bit busy, en, isid, erd, ewr;
    busy = (m_cnt > 0);
    en   = (m_ind != 0) && !busy;
    isid = is_id(m_addr);
    erd  = s && !w && off == 3 && en && !isid;
    ewr  = s &&  w && off == 3 && en && !isid;
    check(ib_srst == busy, "R8 srst", int'(ib_srst), int'(busy));
    check(ping_block == m_pb[0], "R2 ping_block", int'(ping_block), m_pb);
    check(host_rdata == 8'(m_hr), "R1 host_rdata", int'(host_rdata), m_hr);
    check(ib_rd == erd, "R4 ib_rd", int'(ib_rd), int'(erd));
    check(ib_wr == ewr, "R5 ib_wr", int'(ib_wr), int'(ewr));
    if (erd || ewr)
      check(int'(ib_addr) == m_addr, "R6 ib_addr", int'(ib_addr), m_addr);
    if (ewr)
      check(int'(ib_wdata) == d, "R5 ib_wdata", int'(ib_wdata), d);
  endtask

  task automatic model_update(input bit s, input bit w, input int off, input int d);
    bit busy, en, isid;
    busy = (m_cnt > 0);
    en   = (m_ind != 0) && !busy;
    isid = is_id(m_addr);
    if (s && !w) begin
      case (off)
        0: m_hr = (busy ? 8'h80 : 0) | (m_pb << 4) | (m_ai << 1) | m_ind;
        1: m_hr = en ? (m_addr >> 8) : 0;
        2: m_hr = en ? (m_addr & 8'hFF) : 0;
        default: m_hr = !en ? 0 : isid ? ((m_addr == 16'h0017) ? (m_id >> 8) : (m_id & 8'hFF))
                                      : mem_byte(m_addr);
      endcase
    end
    if (busy) begin
      m_cnt--; m_pb = 0; m_ai = 0; m_ind = 0; m_addr = 0; m_id = 16'h07D0;
    end else if (s && w) begin
      case (off)
        0: if ((d & 8'h80) != 0) begin
             m_cnt = NRST; m_pb = 0; m_ai = 0; m_ind = 0; m_addr = 0; m_id = 16'h07D0;
           end else begin
             m_pb = (d >> 4) & 1; m_ai = (d >> 1) & 1; m_ind = d & 1;
           end
        1: if (en) m_addr = ((d & 8'hFF) << 8) | (m_addr & 8'hFF);
        2: if (en) m_addr = (m_addr & 16'hFF00) | (d & 8'hFF);
        default: if (en) begin
          if (isid) begin
            if (m_addr == 16'h0017) m_id = ((d & 8'hFF) << 8) | (m_id & 8'hFF);
            else                    m_id = (m_id & 16'hFF00) | (d & 8'hFF);
          end
          if (m_ai != 0) m_addr = (m_addr + 1) & 16'hFFFF;
        end
      endcase
    end else if (s && off == 3 && en && m_ai != 0) begin
      m_addr = (m_addr + 1) & 16'hFFFF;
    end
  endtask

  task automatic step(input bit s, input bit w, input int off, input int d);
    @(negedge clk);
    host_sel   = s;
    host_wr    = w;
    host_off   = 2'(off);
    host_wdata = 8'(d);
    #1;
    compare(s, w, off, d);
    model_update(s, w, off, d);
  endtask

  task automatic wr(input int off, input int d);
    step(1'b1, 1'b1, off, d);
  endtask

  task automatic rd(input int off, input int exp, input string req);
    step(1'b1, 1'b0, off, 0);
    step(1'b0, 1'b0, 0, 0);
    check(int'(host_rdata) == exp, req, int'(host_rdata), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_pb = 0; m_ai = 0; m_ind = 0; m_addr = 0; m_id = 16'h07D0; m_hr = 0;
    host_sel = 0; host_wr = 0; host_off = 0; host_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(3);

    // R11 reset state
    check(ib_srst == 1'b0, "R11 srst", int'(ib_srst), 0);
    check(ping_block == 1'b0, "R11 ping_block", int'(ping_block), 0);
    rd(0, 8'h00, "R11 mode");

    // R3 ports inert without indirect bit
    wr(1, 8'h12);
    rd(1, 8'h00, "R3 ptr read");
    wr(3, 8'h55);

    // R2 mode fields; unstored bits read 0
    wr(0, 8'h6F);
    rd(0, 8'h03, "R2 mode drop");
    wr(0, 8'h13);
    rd(0, 8'h13, "R2 mode");
    check(ping_block == 1'b1, "R2 ping", int'(ping_block), 1);

    // R1 pointer load and readback
    wr(1, 8'h12);
    wr(2, 8'h34);
    rd(1, 8'h12, "R1 hi");
    rd(2, 8'h34, "R1 lo");

    // R4 data read, R6 step
    rd(3, 8'h7C, "R4 data");
    rd(2, 8'h35, "R6 step");
    wr(3, 8'hA1);
    wr(0, 8'h13);
    rd(2, 8'h36, "R7 mode keeps ptr");

    // R6 wrap
    wr(1, 8'hFF);
    wr(2, 8'hFE);
    wr(3, 8'h01);
    wr(3, 8'h02);
    wr(3, 8'h03);
    rd(1, 8'h00, "R6 wrap hi");
    rd(2, 8'h01, "R6 wrap lo");

    // R6 no increment
    wr(0, 8'h01);
    wr(1, 8'h20);
    wr(2, 8'h00);
    rd(3, mem_byte(16'h2000), "R4 read a");
    rd(3, mem_byte(16'h2000), "R6 hold");
    rd(2, 8'h00, "R6 hold ptr");

    // R9 identity
    wr(0, 8'h03);
    wr(1, 8'h00);
    wr(2, 8'h17);
    rd(3, 8'h07, "R9 id hi");
    rd(3, 8'hD0, "R9 id lo");
    wr(2, 8'h17);
    wr(3, 8'hAB);
    wr(2, 8'h17);
    rd(3, 8'hAB, "R9 id write");

    // R8 soft reset
    wr(0, 8'h93);
    rd(0, 8'h80, "R8 busy mode");
    wr(0, 8'h03);
    idle(4);
    rd(0, 8'h00, "R8 self clear");
    check(ping_block == 1'b0, "R8 ping cleared", int'(ping_block), 0);
    wr(0, 8'h03);
    rd(1, 8'h00, "R8 ptr cleared");
    wr(2, 8'h17);
    rd(3, 8'h07, "R9 id restored hi");
    rd(3, 8'hD0, "R9 id restored lo");
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule